// File: doc/BRIEF.md
# Segmented Address Translator

This block maps 16-bit virtual addresses onto physical addresses through a small table of segment descriptors held inside the block. The top bits of each virtual address pick a descriptor. The rest of the address is an offset into that segment. Each descriptor holds a base, an upper offset bound, a present flag and three access rights: read, write and execute. The block adds the base to the offset. It reports a fault when the descriptor is not present, when the offset lies past the bound, or when the access kind is not granted.

Requests arrive with a valid/ready handshake and carry an address and an access kind: load, store or instruction fetch. Each request returns one registered response one cycle later, holding the physical address and a two-bit fault code. The descriptors are loaded through a separate write port. That port accepts a write only when the privilege qualifier is asserted, as a kernel would do when it switches processes.

Top module: `seg_xlat`

## Requirements
- R1: Bits 15:14 of the virtual address select the descriptor and bits 13:0 are the offset. With no fault, the physical address is the descriptor base plus the zero-extended offset, truncated to 16 bits so that any carry out is dropped.
- R2: An access through a descriptor whose present flag is clear returns fault code 2'b01.
- R3: An offset strictly greater than the descriptor bound returns fault code 2'b10. An offset equal to the bound translates normally.
- R4: The rights field is bit 0 read, bit 1 write and bit 2 execute. The access kind is 2'b00 load, 2'b01 store and 2'b10 fetch, and each kind needs its matching bit. The kind value 2'b11 is never granted. A refused access returns fault code 2'b11.
- R5: When several faults apply, not-present ranks above out-of-bound, and out-of-bound ranks above rights.
- R6: A response with a nonzero fault code carries physical address 0. Fault code 2'b00 means no fault.
- R7: A request accepted at a clock edge gives rsp_valid_o high after that edge. While rsp_ready_i is low, the response stays stable and req_ready_o stays low. With rsp_ready_i high, a new request is accepted every cycle.
- R8: A descriptor write takes effect only when cfg_we_i and cfg_priv_i are both high. Without cfg_priv_i, the write leaves the table unchanged.
- R9: A descriptor write in the same cycle as an accepted request does not affect that request. It applies from the next request on.
- R10: After reset no response is pending and every descriptor is not present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_addr_i | input | 16 | Virtual address |
| req_kind_i | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response consumer ready |
| rsp_paddr_o | output | 16 | Physical address, 0 on fault |
| rsp_fault_o | output | 2 | Fault code |
| cfg_we_i | input | 1 | Descriptor write enable |
| cfg_priv_i | input | 1 | Privilege qualifier for descriptor writes |
| cfg_idx_i | input | 2 | Descriptor index to write |
| cfg_base_i | input | 16 | New base |
| cfg_limit_i | input | 14 | New offset bound |
| cfg_present_i | input | 1 | New present flag |
| cfg_rights_i | input | 3 | New rights: bit 0 read, bit 1 write, bit 2 execute |

## Verification
The bench builds the block with its default parameters: two segment-select bits (four descriptors), a 14-bit offset and a 16-bit physical address. With these values a base near the top of the space pushes the sum past 16 bits, so the dropped carry is exercised. The bench also drives offsets exactly at the bound and one past it, and every combination of present flag, rights and access kind, including the unassigned kind. Random reprogramming with and without privilege, mixed with random requests, covers ordering between table writes and translations.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_ABSENT  = 2'b01,
    FLT_BOUND   = 2'b10,
    FLT_RIGHTS  = 2'b11
  } fault_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  localparam int RIGHTS_W = 3;
  localparam int RT_READ  = 0;
  localparam int RT_WRITE = 1;
  localparam int RT_EXEC  = 2;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_W = 2,
  parameter int OFF_W = 14,
  parameter int PA_W  = 16,
  localparam int NSEG = 1 << SEG_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [SEG_W-1:0]                  wr_idx_i,
  input  logic [PA_W-1:0]                   wr_base_i,
  input  logic [OFF_W-1:0]                  wr_limit_i,
  input  logic                              wr_present_i,
  input  logic [seg_xlat_pkg::RIGHTS_W-1:0] wr_rights_i,
  input  logic [SEG_W-1:0]                  rd_idx_i,
  output logic [PA_W-1:0]                   rd_base_o,
  output logic [OFF_W-1:0]                  rd_limit_o,
  output logic                              rd_present_o,
  output logic [seg_xlat_pkg::RIGHTS_W-1:0] rd_rights_o
);
  logic [PA_W-1:0]                   base_q    [NSEG];
  logic [OFF_W-1:0]                  limit_q   [NSEG];
  logic                              present_q [NSEG];
  logic [seg_xlat_pkg::RIGHTS_W-1:0] rights_q  [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]    <= '0;
        limit_q[g]   <= '0;
        present_q[g] <= 1'b0;
        rights_q[g]  <= '0;
      end else if (we_i && wr_idx_i == SEG_W'(g)) begin
        base_q[g]    <= wr_base_i;
        limit_q[g]   <= wr_limit_i;
        present_q[g] <= wr_present_i;
        rights_q[g]  <= wr_rights_i;
      end
    end
  end

  assign rd_base_o    = base_q[rd_idx_i];
  assign rd_limit_o   = limit_q[rd_idx_i];
  assign rd_present_o = present_q[rd_idx_i];
  assign rd_rights_o  = rights_q[rd_idx_i];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlat_pkg::*;
#(
  parameter int OFF_W = 14,
  parameter int PA_W  = 16
) (
  input  logic [OFF_W-1:0]    offset_i,
  input  logic [1:0]          kind_i,
  input  logic [PA_W-1:0]     base_i,
  input  logic [OFF_W-1:0]    limit_i,
  input  logic                present_i,
  input  logic [RIGHTS_W-1:0] rights_i,
  output logic [PA_W-1:0]     paddr_o,
  output logic [1:0]          fault_o
);
  logic [PA_W-1:0] sum;
  logic            granted;
  fault_e          flt;

  // carry out of the add is dropped by width
  assign sum = base_i + PA_W'(offset_i);

  always_comb begin
    unique case (acc_e'(kind_i))
      ACC_LOAD:  granted = rights_i[RT_READ];
      ACC_STORE: granted = rights_i[RT_WRITE];
      ACC_FETCH: granted = rights_i[RT_EXEC];
      default:   granted = 1'b0;
    endcase
  end

  always_comb begin
    if (!present_i)            flt = FLT_ABSENT;
    else if (offset_i > limit_i) flt = FLT_BOUND;
    else if (!granted)         flt = FLT_RIGHTS;
    else                       flt = FLT_NONE;
  end

  assign fault_o = flt;
  assign paddr_o = (flt == FLT_NONE) ? sum : '0;
endmodule

// File: rtl/seg_rsp_reg.sv
module seg_rsp_reg #(
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o
);
  assign in_ready_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (in_valid_i && in_ready_o) begin
      out_valid_o <= 1'b1;
      out_data_o  <= in_data_i;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
  import seg_xlat_pkg::*;
#(
  parameter int VA_W  = 16,
  parameter int SEG_W = 2,
  parameter int PA_W  = 16,
  localparam int OFF_W = VA_W - SEG_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [VA_W-1:0]     req_addr_i,
  input  logic [1:0]          req_kind_i,
  output logic                rsp_valid_o,
  input  logic                rsp_ready_i,
  output logic [PA_W-1:0]     rsp_paddr_o,
  output logic [1:0]          rsp_fault_o,
  input  logic                cfg_we_i,
  input  logic                cfg_priv_i,
  input  logic [SEG_W-1:0]    cfg_idx_i,
  input  logic [PA_W-1:0]     cfg_base_i,
  input  logic [OFF_W-1:0]    cfg_limit_i,
  input  logic                cfg_present_i,
  input  logic [RIGHTS_W-1:0] cfg_rights_i
);
  localparam int RSP_W = PA_W + 2;

  logic [SEG_W-1:0]    seg_idx;
  logic [OFF_W-1:0]    offset;
  logic [PA_W-1:0]     ent_base;
  logic [OFF_W-1:0]    ent_limit;
  logic                ent_present;
  logic [RIGHTS_W-1:0] ent_rights;
  logic [PA_W-1:0]     xl_paddr;
  logic [1:0]          xl_fault;
  logic [RSP_W-1:0]    rsp_data;

  assign seg_idx = req_addr_i[VA_W-1 -: SEG_W];
  assign offset  = req_addr_i[OFF_W-1:0];

  seg_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (cfg_we_i && cfg_priv_i),
    .wr_idx_i     (cfg_idx_i),
    .wr_base_i    (cfg_base_i),
    .wr_limit_i   (cfg_limit_i),
    .wr_present_i (cfg_present_i),
    .wr_rights_i  (cfg_rights_i),
    .rd_idx_i     (seg_idx),
    .rd_base_o    (ent_base),
    .rd_limit_o   (ent_limit),
    .rd_present_o (ent_present),
    .rd_rights_o  (ent_rights)
  );

  seg_check #(.OFF_W(OFF_W), .PA_W(PA_W)) u_check (
    .offset_i  (offset),
    .kind_i    (req_kind_i),
    .base_i    (ent_base),
    .limit_i   (ent_limit),
    .present_i (ent_present),
    .rights_i  (ent_rights),
    .paddr_o   (xl_paddr),
    .fault_o   (xl_fault)
  );

  seg_rsp_reg #(.DATA_W(RSP_W)) u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (req_valid_i),
    .in_ready_o  (req_ready_o),
    .in_data_i   ({xl_fault, xl_paddr}),
    .out_valid_o (rsp_valid_o),
    .out_ready_i (rsp_ready_i),
    .out_data_o  (rsp_data)
  );

  assign rsp_paddr_o = rsp_data[PA_W-1:0];
  assign rsp_fault_o = rsp_data[RSP_W-1 -: 2];
endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
  parameter int PA_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            rsp_valid_o,
  input logic            rsp_ready_i,
  input logic [PA_W-1:0] rsp_paddr_o,
  input logic [1:0]      rsp_fault_o
);
  assert_fault_no_pa_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o != 2'b00 |-> rsp_paddr_o == '0);

  assert_accept_resp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> rsp_valid_o);

  assert_hold_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o));

  assert_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |-> !req_ready_o);

  assert_drain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ready_i && !req_valid_i |=> !rsp_valid_o);
endmodule

bind seg_xlat seg_xlat_chk #(.PA_W(PA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_paddr_o (rsp_paddr_o),
  .rsp_fault_o (rsp_fault_o)
);

// File: tb/seg_xlat_tb.sv
`timescale 1ns/1ps
module seg_xlat_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        cfg_we = 1'b0;
  logic        cfg_priv = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [15:0] cfg_base = '0;
  logic [13:0] cfg_limit = '0;
  logic        cfg_present = 1'b0;
  logic [2:0]  cfg_rights = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_base [4];
  logic [13:0] m_limit [4];
  logic        m_present [4];
  logic [2:0]  m_rights [4];

  always #2 clk = ~clk;

  seg_xlat u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_kind_i(req_kind),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault),
    .cfg_we_i(cfg_we), .cfg_priv_i(cfg_priv), .cfg_idx_i(cfg_idx),
    .cfg_base_i(cfg_base), .cfg_limit_i(cfg_limit),
    .cfg_present_i(cfg_present), .cfg_rights_i(cfg_rights)
  );

  function automatic logic [17:0] expect_rsp(logic [15:0] a, logic [1:0] k);
    logic [1:0]  s = a[15:14];
    logic [13:0] o = a[13:0];
    logic        ok;
    case (k)
      2'b00: ok = m_rights[s][0];
      2'b01: ok = m_rights[s][1];
      2'b10: ok = m_rights[s][2];
      default: ok = 1'b0;
    endcase
    if (!m_present[s])      return {2'b01, 16'h0};
    if (o > m_limit[s])     return {2'b10, 16'h0};
    if (!ok)                return {2'b11, 16'h0};
    return {2'b00, 16'(m_base[s] + {2'b00, o})};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_rsp(input string tag, input logic [17:0] exp);
    check(rsp_valid === 1'b1, tag, "rsp_valid", 32'(rsp_valid), 32'd1);
    check({rsp_fault, rsp_paddr} === exp, tag, "fault/paddr",
          32'({rsp_fault, rsp_paddr}), 32'(exp));
  endtask

  task automatic cfg_write(input logic [1:0] idx, input logic [15:0] b, input logic [13:0] l,
                           input logic p, input logic [2:0] r, input logic priv);
    @(negedge clk);
    cfg_we = 1'b1; cfg_priv = priv; cfg_idx = idx; cfg_base = b;
    cfg_limit = l; cfg_present = p; cfg_rights = r;
    @(negedge clk);
    cfg_we = 1'b0;
    if (priv) begin
      m_base[idx] = b; m_limit[idx] = l; m_present[idx] = p; m_rights[idx] = r;
    end
  endtask

  task automatic xact(input logic [15:0] a, input logic [1:0] k, input string tag);
    logic [17:0] e;
    e = expect_rsp(a, k);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_kind = k;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(tag, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [17:0] ea, eb, e_old;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin
      m_base[i] = '0; m_limit[i] = '0; m_present[i] = 1'b0; m_rights[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: nothing pending, all descriptors absent
    check(rsp_valid === 1'b0, "R10", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    for (int s = 0; s < 4; s++)
      xact({2'(s), 14'h0010}, 2'b00, "R10");

    cfg_write(2'd0, 16'h4000, 14'h0FFF, 1'b1, 3'b101, 1'b1);
    cfg_write(2'd1, 16'h4800, 14'h13FF, 1'b1, 3'b011, 1'b1);
    cfg_write(2'd3, 16'hF000, 14'h3FFF, 1'b1, 3'b111, 1'b1);

    // R1: examples and dropped carry
    xact(16'h0240, 2'b10, "R1");
    check(rsp_paddr === 16'h4240, "R1", "fetch 0x0240", 32'(rsp_paddr), 32'h4240);
    xact(16'h4050, 2'b00, "R1");
    check(rsp_paddr === 16'h4850, "R1", "load 0x4050", 32'(rsp_paddr), 32'h4850);
    xact(16'hD234, 2'b01, "R1");
    check(rsp_paddr === 16'h0234, "R1", "carry wrap", 32'(rsp_paddr), 32'h0234);
    // R2
    xact(16'h8000, 2'b00, "R2");
    check(rsp_fault === 2'b01, "R2", "absent", 32'(rsp_fault), 32'd1);
    // R3: bound edges
    xact(16'h0FFF, 2'b00, "R3");
    check(rsp_fault === 2'b00, "R3", "at bound", 32'(rsp_fault), 32'd0);
    xact(16'h1000, 2'b00, "R3");
    check(rsp_fault === 2'b10, "R3", "past bound", 32'(rsp_fault), 32'd2);
    // R4: rights per kind
    xact(16'h0100, 2'b01, "R4");
    check(rsp_fault === 2'b11, "R4", "store to r-x", 32'(rsp_fault), 32'd3);
    xact(16'h4100, 2'b10, "R4");
    check(rsp_fault === 2'b11, "R4", "fetch from rw-", 32'(rsp_fault), 32'd3);
    xact(16'h4100, 2'b01, "R4");
    xact(16'hC000, 2'b11, "R4");
    check(rsp_fault === 2'b11, "R4", "reserved kind", 32'(rsp_fault), 32'd3);
    // R5: priority
    xact(16'h3FFF, 2'b01, "R5");
    check(rsp_fault === 2'b10, "R5", "bound over rights", 32'(rsp_fault), 32'd2);
    xact(16'hBFFF, 2'b11, "R5");
    check(rsp_fault === 2'b01, "R5", "absent over all", 32'(rsp_fault), 32'd1);
    // R6
    xact(16'h1000, 2'b00, "R6");
    check(rsp_paddr === 16'h0, "R6", "fault paddr zero", 32'(rsp_paddr), 32'd0);

    // R8: unprivileged write ignored
    cfg_write(2'd2, 16'h1000, 14'h3FFF, 1'b1, 3'b111, 1'b0);
    xact(16'h8004, 2'b00, "R8");
    check(rsp_fault === 2'b01, "R8", "unpriv write ignored", 32'(rsp_fault), 32'd1);

    // R9: write alongside request applies to next one
    e_old = expect_rsp(16'h0300, 2'b00);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h0300; req_kind = 2'b00;
    cfg_we = 1'b1; cfg_priv = 1'b1; cfg_idx = 2'd0; cfg_base = 16'h2000;
    cfg_limit = 14'h0FFF; cfg_present = 1'b1; cfg_rights = 3'b001;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    check_rsp("R9", e_old);
    m_base[0] = 16'h2000; m_rights[0] = 3'b001;
    xact(16'h0300, 2'b00, "R9");
    check(rsp_paddr === 16'h2300, "R9", "new base next", 32'(rsp_paddr), 32'h2300);

    // R7: backpressure
    ea = expect_rsp(16'h4010, 2'b00);
    eb = expect_rsp(16'hC123, 2'b10);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 16'h4010; req_kind = 2'b00;
    @(negedge clk);
    check_rsp("R7", ea);
    req_addr = 16'hC123; req_kind = 2'b10;
    #0.5;
    check(req_ready === 1'b0, "R7", "stall ready", 32'(req_ready), 32'd0);
    @(negedge clk);
    check_rsp("R7", ea);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp("R7", eb);
    @(negedge clk);
    check(rsp_valid === 1'b0, "R7", "drained", 32'(rsp_valid), 32'd0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(7) == 0)
        cfg_write(2'($urandom), 16'($urandom), 14'($urandom), 1'($urandom_range(3) != 0),
                  3'($urandom), 1'($urandom_range(3) != 0));
      else
        xact(16'($urandom), 2'($urandom), "R1/R2/R3/R4/R5/R8");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule